// File: doc/BRIEF.md
# Handshake Register Port for a Lookup Table Controller

This block is the host-facing register port of a content-addressable lookup engine. The host runs an asynchronous select/acknowledge handshake over a 3-bit address, a 16-bit data path and a write-enable line. Every host strobe passes through a synchronizer into the internal clock domain. A small state machine answers each transfer by pulling acknowledge low, and it releases acknowledge only after the host has let go of select.

The port holds the status flags, an error word, an almost-full threshold, a match mask, two argument words and a command word. Writing the command word forwards a one-cycle command, with its 32-bit argument, to the table and queue logic. Any further write is stalled by holding acknowledge back until that command reports completion. A write is also stalled while the table logic signals a busy internal operation. When a command completes, the port raises a low interrupt pulse once no transfer is in progress.

Top module: `cam_host_port`

## Requirements
- R1: A read starts when the synchronized select is low and write-enable is high. Acknowledge then goes low, and at the same time `dq_o` carries the addressed register and `dq_oe` is 1.
- R2: A write starts when the synchronized select is low and write-enable is low. The value on `dq_i` is stored in the addressed register, and acknowledge goes low.
- R3: Acknowledge stays low for as long as select stays low. It returns high only after select has been seen high. `dq_oe` drops in the same cycle that acknowledge returns high.
- R4: A write is stalled, with acknowledge held high, while `tbl_busy` is 1 or while an issued command has not yet been answered by `cmd_done`. Reads are never stalled.
- R5: After reset, with `q_empty` and `tbl_init` high, the registers read as follows: flag (address 0) is 0x001C, error (address 1) is 0xFFFF, almost-full (address 2) is 0x3FFF and mask (address 3) is 0x0000. Both `ack_n` and `irq_n` are high.
- R6: In the flag register, bit 10 is last-operation-complete. It is cleared when a command is issued and set by `cmd_done`. Bit 4 follows `q_empty` and bit 2 follows `tbl_init`. Bit 3 is the entry mode: it is writable and appears on `entry_mode`. All other flag bits read 0 and ignore writes.
- R7: A write to address 4 pulses `cmd_valid` for exactly one cycle. During that cycle `cmd_word` holds the written value and `cmd_arg` holds {address 6, address 5}.
- R8: Each `cmd_done` yields exactly one low pulse on `irq_n`, lasting IRQ_CYC clocks (default 2). The pulse is held back while a transfer is in progress and starts after acknowledge has returned high.
- R9: On `cmd_done` the error register loads `cmd_status`. Any host write to the error register sets it back to 0xFFFF.
- R10: The almost-full register (address 2) and the mask register (address 3) can be both read and written. They drive `af_thresh` and `match_mask`.
- R11: Address 7 reads as 0x0000, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset, held for at least two clocks |
| sel_n | input | 1 | Host select, active low, asynchronous |
| we_n | input | 1 | Host write-enable, low for a write |
| addr | input | 3 | Register address |
| dq_i | input | 16 | Host write data (input half of the bidirectional bus) |
| dq_o | output | 16 | Read data (output half of the bidirectional bus) |
| dq_oe | output | 1 | Read data output enable |
| ack_n | output | 1 | Transfer acknowledge, active low |
| irq_n | output | 1 | Command-complete interrupt, active-low pulse |
| q_empty | input | 1 | Entry queue empty status from the queue logic |
| tbl_init | input | 1 | Table initialized status from the table logic |
| tbl_busy | input | 1 | Internal operation in progress, blocks writes |
| cmd_done | input | 1 | One-cycle command completion strobe |
| cmd_status | input | 16 | Completion status, loaded into the error register |
| cmd_valid | output | 1 | One-cycle command issue strobe |
| cmd_word | output | 16 | Issued command word |
| cmd_arg | output | 32 | Issued command argument |
| af_thresh | output | 16 | Almost-full threshold |
| match_mask | output | 16 | Match mask |
| entry_mode | output | 1 | Entry mode bit of the flag register |

## Verification
The assertions check several rules on every cycle: that acknowledge only falls after select was low and only rises after select was high, that the read drive never outlasts acknowledge, that no write is acknowledged while a blocking condition was present, that the command strobe lasts a single cycle, and that the interrupt pulse is never shorter than its minimum. Only the bench scenarios can show the rest. These are the register contents and reset values read back over the handshake, the ignored flag bits and the unused address, the command word and argument as issued, the length of a stall against the moment `cmd_done` arrives, and an interrupt that is held back behind an ongoing transfer.

// File: rtl/cam_host_port_pkg.sv
package cam_host_port_pkg;
    localparam int DW = 16;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        RA_FLAG  = 3'd0,
        RA_ERR   = 3'd1,
        RA_AFULL = 3'd2,
        RA_MASK  = 3'd3,
        RA_CMD   = 3'd4,
        RA_ARGL  = 3'd5,
        RA_ARGH  = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_STALL = 2'd1,
        HS_ACK   = 2'd2
    } hs_state_e;

    localparam int FB_TINIT = 2;
    localparam int FB_MODE  = 3;
    localparam int FB_QEMP  = 4;
    localparam int FB_LDONE = 10;

    localparam logic [DW-1:0] ERR_RST   = 16'hFFFF;
    localparam logic [DW-1:0] AFULL_RST = 16'h3FFF;

    typedef struct packed {
        logic ldone;
        logic qemp;
        logic mode;
        logic tinit;
    } flag_t;

    function automatic logic [DW-1:0] pack_flag(flag_t f);
        logic [DW-1:0] v;
        v = '0;
        v[FB_LDONE] = f.ldone;
        v[FB_QEMP]  = f.qemp;
        v[FB_MODE]  = f.mode;
        v[FB_TINIT] = f.tinit;
        return v;
    endfunction
endpackage

// File: rtl/chp_sync.sv
module chp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= INIT;
        else     stage[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= INIT;
            else     stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/chp_handshake.sv
module chp_handshake
    import cam_host_port_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_s_n,
    input  logic          we_s_n,
    input  logic          blocked,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic          ack_n,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    output logic          xfer_active
);
    hs_state_e state;

    logic want_wr;
    assign want_wr = !sel_s_n && !we_s_n;
    assign wr_en = (state == HS_IDLE || state == HS_STALL) && want_wr && !blocked;
    assign xfer_active = (state != HS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
            ack_n <= 1'b1;
            dq_o  <= '0;
            dq_oe <= 1'b0;
        end else begin
            unique case (state)
                HS_IDLE: begin
                    if (!sel_s_n) begin
                        if (we_s_n) begin
                            dq_o  <= rd_data;
                            dq_oe <= 1'b1;
                            ack_n <= 1'b0;
                            state <= HS_ACK;
                        end else if (blocked) begin
                            state <= HS_STALL;
                        end else begin
                            ack_n <= 1'b0;
                            state <= HS_ACK;
                        end
                    end
                end
                HS_STALL: begin
                    if (sel_s_n) begin
                        state <= HS_IDLE;
                    end else if (!blocked) begin
                        ack_n <= 1'b0;
                        state <= HS_ACK;
                    end
                end
                HS_ACK: begin
                    if (sel_s_n) begin
                        ack_n <= 1'b1;
                        dq_oe <= 1'b0;
                        state <= HS_IDLE;
                    end
                end
                default: state <= HS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/chp_regs.sv
module chp_regs
    import cam_host_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rd_data,
    input  logic            q_empty,
    input  logic            tbl_init,
    input  logic            cmd_done,
    input  logic [DW-1:0]   cmd_status,
    output logic            cmd_valid,
    output logic [DW-1:0]   cmd_word,
    output logic [2*DW-1:0] cmd_arg,
    output logic [DW-1:0]   af_thresh,
    output logic [DW-1:0]   match_mask,
    output logic            entry_mode,
    output logic            op_pending
);
    flag_t         flag;
    logic [DW-1:0] err_q, arg_lo, arg_hi;
    reg_addr_e     ra;

    assign ra = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag       <= '{ldone: 1'b0, qemp: 1'b1, mode: 1'b1, tinit: 1'b1};
            err_q      <= ERR_RST;
            af_thresh  <= AFULL_RST;
            match_mask <= '0;
            arg_lo     <= '0;
            arg_hi     <= '0;
            cmd_word   <= '0;
            cmd_valid  <= 1'b0;
            op_pending <= 1'b0;
        end else begin
            flag.qemp  <= q_empty;
            flag.tinit <= tbl_init;
            cmd_valid  <= 1'b0;
            if (cmd_done) begin
                flag.ldone <= 1'b1;
                op_pending <= 1'b0;
                err_q      <= cmd_status;
            end
            if (wr_en) begin
                unique case (ra)
                    RA_FLAG:  flag.mode  <= wdata[FB_MODE];
                    RA_ERR:   err_q      <= ERR_RST;
                    RA_AFULL: af_thresh  <= wdata;
                    RA_MASK:  match_mask <= wdata;
                    RA_CMD: begin
                        cmd_word   <= wdata;
                        cmd_valid  <= 1'b1;
                        op_pending <= 1'b1;
                        flag.ldone <= 1'b0;
                    end
                    RA_ARGL:  arg_lo     <= wdata;
                    RA_ARGH:  arg_hi     <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (ra)
            RA_FLAG:  rd_data = pack_flag(flag);
            RA_ERR:   rd_data = err_q;
            RA_AFULL: rd_data = af_thresh;
            RA_MASK:  rd_data = match_mask;
            RA_CMD:   rd_data = cmd_word;
            RA_ARGL:  rd_data = arg_lo;
            RA_ARGH:  rd_data = arg_hi;
            default:  rd_data = '0;
        endcase
    end

    assign cmd_arg    = {arg_hi, arg_lo};
    assign entry_mode = flag.mode;
endmodule

// File: rtl/chp_irq.sv
module chp_irq #(
    parameter int IRQ_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic xfer_active,
    output logic irq_n
);
    localparam int CW = $clog2(IRQ_CYC + 1);

    logic          pend;
    logic [CW-1:0] cnt;
    logic          start;

    assign start = pend && !xfer_active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else begin
            if (done)       pend <= 1'b1;
            else if (start) pend <= 1'b0;
            if (start)            cnt <= CW'(IRQ_CYC);
            else if (cnt != '0)   cnt <= cnt - 1'b1;
        end
    end

    assign irq_n = (cnt == '0);
endmodule

// File: rtl/cam_host_port.sv
module cam_host_port
    import cam_host_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IRQ_CYC     = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_n,
    input  logic            we_n,
    input  logic [2:0]      addr,
    input  logic [15:0]     dq_i,
    output logic [15:0]     dq_o,
    output logic            dq_oe,
    output logic            ack_n,
    output logic            irq_n,
    input  logic            q_empty,
    input  logic            tbl_init,
    input  logic            tbl_busy,
    input  logic            cmd_done,
    input  logic [15:0]     cmd_status,
    output logic            cmd_valid,
    output logic [15:0]     cmd_word,
    output logic [31:0]     cmd_arg,
    output logic [15:0]     af_thresh,
    output logic [15:0]     match_mask,
    output logic            entry_mode
);
    logic          sel_s_n, we_s_n;
    logic          wr_en, xfer_active, op_pending, blocked;
    logic [DW-1:0] rd_data;

    chp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sel_n, we_n}),
        .q   ({sel_s_n, we_s_n})
    );

    assign blocked = tbl_busy || op_pending;

    chp_handshake u_hs (
        .clk         (clk),
        .rst         (rst),
        .sel_s_n     (sel_s_n),
        .we_s_n      (we_s_n),
        .blocked     (blocked),
        .rd_data     (rd_data),
        .wr_en       (wr_en),
        .ack_n       (ack_n),
        .dq_o        (dq_o),
        .dq_oe       (dq_oe),
        .xfer_active (xfer_active)
    );

    chp_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (dq_i),
        .rd_data    (rd_data),
        .q_empty    (q_empty),
        .tbl_init   (tbl_init),
        .cmd_done   (cmd_done),
        .cmd_status (cmd_status),
        .cmd_valid  (cmd_valid),
        .cmd_word   (cmd_word),
        .cmd_arg    (cmd_arg),
        .af_thresh  (af_thresh),
        .match_mask (match_mask),
        .entry_mode (entry_mode),
        .op_pending (op_pending)
    );

    chp_irq #(.IRQ_CYC(IRQ_CYC)) u_irq (
        .clk         (clk),
        .rst         (rst),
        .done        (cmd_done),
        .xfer_active (xfer_active),
        .irq_n       (irq_n)
    );
endmodule

// File: rtl/cam_host_port_chk.sv
module cam_host_port_chk #(
    parameter int IRQ_CYC = 2
) (
    input logic clk,
    input logic rst,
    input logic sel_n,
    input logic we_n,
    input logic ack_n,
    input logic dq_oe,
    input logic irq_n,
    input logic tbl_busy,
    input logic op_pending,
    input logic cmd_valid
);
    // R1 / R2: acknowledge falls only after select was seen low
    p_ack_after_sel_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_n) |-> !$past(sel_n, 2));

    // R3: acknowledge rises only after select was seen high
    p_ack_release_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_n) |-> $past(sel_n, 2));

    // R3: read drive never outlasts acknowledge
    p_oe_in_ack_r3: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !ack_n);

    // R4: no write acknowledged while a blocking condition was present
    p_no_blocked_write_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack_n) && !we_n) |-> (!$past(tbl_busy) && !$past(op_pending)));

    // R5: port is quiet in the first cycle after reset
    p_reset_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ack_n && irq_n && !dq_oe && !cmd_valid));

    // R7: command strobe lasts one cycle
    p_cmd_single_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R8: interrupt pulse never shorter than two clocks
    if (IRQ_CYC >= 2) begin : g_irq_width
        p_irq_width_r8: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_n) |-> !$past(irq_n, 2));
    end
endmodule

bind cam_host_port cam_host_port_chk #(.IRQ_CYC(IRQ_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_n      (sel_n),
    .we_n       (we_n),
    .ack_n      (ack_n),
    .dq_oe      (dq_oe),
    .irq_n      (irq_n),
    .tbl_busy   (tbl_busy),
    .op_pending (op_pending),
    .cmd_valid  (cmd_valid)
);

// File: tb/cam_host_port_tb.sv
module cam_host_port_tb;
    localparam int IRQ_CYC = 2;
    localparam int TMO = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, we_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [15:0] dq_i = '0;
    logic [15:0] dq_o;
    logic        dq_oe, ack_n, irq_n;
    logic        q_empty = 1'b1, tbl_init = 1'b1, tbl_busy = 1'b0;
    logic        cmd_done = 1'b0;
    logic [15:0] cmd_status = '0;
    logic        cmd_valid;
    logic [15:0] cmd_word, af_thresh, match_mask;
    logic [31:0] cmd_arg;
    logic        entry_mode;

    int checks = 0, errors = 0;
    int irq_low = 0, irq_falls = 0, cmd_cnt = 0;
    logic        irq_prev = 1'b1;
    logic [15:0] cap_word;
    logic [31:0] cap_arg;

    always #2.5 clk = ~clk;

    cam_host_port #(.SYNC_STAGES(2), .IRQ_CYC(IRQ_CYC)) u_dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .we_n(we_n), .addr(addr),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .ack_n(ack_n), .irq_n(irq_n),
        .q_empty(q_empty), .tbl_init(tbl_init), .tbl_busy(tbl_busy),
        .cmd_done(cmd_done), .cmd_status(cmd_status), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .cmd_arg(cmd_arg), .af_thresh(af_thresh),
        .match_mask(match_mask), .entry_mode(entry_mode)
    );

    always @(negedge clk) begin
        if (!irq_n) irq_low++;
        if (irq_prev && !irq_n) irq_falls++;
        irq_prev = irq_n;
        if (cmd_valid) begin
            cmd_cnt++;
            cap_word = cmd_word;
            cap_arg  = cmd_arg;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wait_ack(logic lvl, output int cyc);
        cyc = 0;
        while (ack_n !== lvl) begin
            @(negedge clk);
            cyc++;
            if (cyc > TMO) begin
                chk("watchdog", 32'(ack_n), 32'(lvl));
                finish_run();
            end
        end
    endtask

    task automatic host_read(logic [2:0] a, output logic [15:0] d);
        int c;
        @(negedge clk);
        addr = a; we_n = 1'b1; sel_n = 1'b0;
        wait_ack(1'b0, c);
        d = dq_oe ? dq_o : 16'hxxxx;
        sel_n = 1'b1;
        wait_ack(1'b1, c);
        @(negedge clk);
    endtask

    task automatic host_write(logic [2:0] a, logic [15:0] d, output int waited);
        int c;
        @(negedge clk);
        addr = a; dq_i = d; we_n = 1'b0; sel_n = 1'b0;
        wait_ack(1'b0, waited);
        sel_n = 1'b1;
        wait_ack(1'b1, c);
        we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_done(logic [15:0] st);
        @(negedge clk);
        cmd_done = 1'b1; cmd_status = st;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R5 ack_n", 32'(ack_n), 32'd1);
        chk("R5 irq_n", 32'(irq_n), 32'd1);
        host_read(3'd0, d); chk("R5 flag", 32'(d), 32'h001C);
        host_read(3'd1, d); chk("R5 error", 32'(d), 32'hFFFF);
        host_read(3'd2, d); chk("R5 almost-full", 32'(d), 32'h3FFF);
        host_read(3'd3, d); chk("R5 mask", 32'(d), 32'h0000);
        chk("R6 entry_mode reset", 32'(entry_mode), 32'd1);
    endtask

    task automatic t_rw();
        logic [15:0] d;
        int w;
        host_write(3'd2, 16'h1234, w);
        host_read(3'd2, d);
        chk("R2 R10 almost-full readback", 32'(d), 32'h1234);
        chk("R10 af_thresh", 32'(af_thresh), 32'h1234);
        host_write(3'd3, 16'hA5A5, w);
        host_read(3'd3, d);
        chk("R10 mask readback", 32'(d), 32'hA5A5);
        chk("R10 match_mask", 32'(match_mask), 32'hA5A5);
    endtask

    task automatic t_flag_unused();
        logic [15:0] d;
        int w;
        host_write(3'd7, 16'hBEEF, w);
        host_read(3'd7, d);
        chk("R11 unused address", 32'(d), 32'h0000);
        host_write(3'd0, 16'hFFF7, w);
        host_read(3'd0, d);
        chk("R6 flag write ignores other bits", 32'(d), 32'h0014);
        chk("R6 entry_mode cleared", 32'(entry_mode), 32'd0);
        host_write(3'd0, 16'h0008, w);
        q_empty = 1'b0; tbl_init = 1'b0;
        repeat (3) @(negedge clk);
        host_read(3'd0, d);
        chk("R6 status bits follow inputs", 32'(d), 32'h0008);
        q_empty = 1'b1; tbl_init = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_hold();
        int c;
        @(negedge clk);
        addr = 3'd2; we_n = 1'b1; sel_n = 1'b0;
        wait_ack(1'b0, c);
        chk("R1 dq_oe during read", 32'(dq_oe), 32'd1);
        chk("R1 read data", 32'(dq_o), 32'h1234);
        repeat (10) @(negedge clk);
        chk("R3 ack held while select low", 32'(ack_n), 32'd0);
        chk("R3 drive held while select low", 32'(dq_oe), 32'd1);
        sel_n = 1'b1;
        wait_ack(1'b1, c);
        chk("R3 drive off with ack release", 32'(dq_oe), 32'd0);
        @(negedge clk);
    endtask

    task automatic t_cmd();
        logic [15:0] d;
        int w, n0, i0;
        host_write(3'd5, 16'h5678, w);
        host_write(3'd6, 16'h9ABC, w);
        n0 = cmd_cnt;
        host_write(3'd4, 16'h0003, w);
        chk("R7 one command strobe", 32'(cmd_cnt - n0), 32'd1);
        chk("R7 command word", 32'(cap_word), 32'h0003);
        chk("R7 command argument", cap_arg, 32'h9ABC5678);
        host_read(3'd0, d);
        chk("R4 R6 read not stalled, bit10 clear", 32'(d), 32'h001C);
        i0 = irq_falls;
        pulse_done(16'h00A1);
        repeat (8) @(negedge clk);
        chk("R8 one irq pulse", 32'(irq_falls - i0), 32'd1);
        host_read(3'd0, d);
        chk("R6 bit10 set by done", 32'(d), 32'h041C);
        host_read(3'd1, d);
        chk("R9 error loads status", 32'(d), 32'h00A1);
    endtask

    task automatic t_irq_width();
        int w, l0;
        host_write(3'd4, 16'h0001, w);
        repeat (4) @(negedge clk);
        l0 = irq_low;
        pulse_done(16'h0000);
        repeat (10) @(negedge clk);
        chk("R8 irq pulse width", 32'(irq_low - l0), 32'(IRQ_CYC));
    endtask

    task automatic t_block_pending();
        logic [15:0] d;
        int w, l0;
        host_write(3'd4, 16'h0002, w);
        l0 = irq_low;
        fork
            host_write(3'd3, 16'h0F0F, w);
            begin
                repeat (20) @(negedge clk);
                chk("R4 write stalled while command pending", 32'(ack_n), 32'd1);
                cmd_done = 1'b1; cmd_status = 16'h0042;
                @(negedge clk);
                cmd_done = 1'b0;
                wait (ack_n == 1'b0);
                chk("R8 irq deferred during transfer", 32'(irq_low - l0), 32'd0);
            end
        join
        chk("R4 stall length", 32'(w >= 20), 32'd1);
        repeat (8) @(negedge clk);
        chk("R8 deferred irq delivered", 32'(irq_low - l0), 32'(IRQ_CYC));
        host_read(3'd3, d);
        chk("R4 stalled write landed", 32'(d), 32'h0F0F);
        host_read(3'd1, d);
        chk("R9 error status 42", 32'(d), 32'h0042);
        host_write(3'd1, 16'h0000, w);
        host_read(3'd1, d);
        chk("R9 write restores no-error", 32'(d), 32'hFFFF);
    endtask

    task automatic t_tbl_busy();
        logic [15:0] d;
        int w;
        tbl_busy = 1'b1;
        host_read(3'd2, d);
        chk("R4 read during busy", 32'(d), 32'h1234);
        fork
            host_write(3'd2, 16'h0F00, w);
            begin
                repeat (15) @(negedge clk);
                chk("R4 write stalled while busy", 32'(ack_n), 32'd1);
                tbl_busy = 1'b0;
            end
        join
        host_read(3'd2, d);
        chk("R4 write after busy", 32'(d), 32'h0F00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_rw();
        t_flag_unused();
        t_hold();
        t_cmd();
        t_irq_width();
        t_block_pending();
        t_tbl_busy();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        finish_run();
    end
endmodule